// File: doc/BRIEF.md
# Dot-Matrix Row Scan Refresh and Attribute Timer

This block drives a multiplexed eight-character display made of 5x7 dot cells. It steps through the seven dot rows one after another. While one row is lit, it reads the character code of every digit for the row that comes next. For each digit it picks either the built-in font row or a user-defined glyph row, and it stores the result in a shadow buffer. At each row change, the shadow buffer becomes the live column pattern.

Within each row slot the columns are gated by a duty window. A three-bit brightness code selects the window from a fixed non-linear table. The block also keeps a slow phase counter that hides characters during half of each period. Per-digit flashing is enabled by a control bit and a per-digit mask. Whole-display blinking always takes precedence over flashing.

The character store, the font ROM and the user glyph store sit outside the block. They are read through a small combinational lookup port that the block steps through.

Top module: `rowscan_refresh`

## Requirements
- R1: While reset is held, row strobe bit 0 is the only active strobe and all 40 column outputs are 0; all timing counters restart from zero when reset is released.
- R2: Exactly one of the 7 row strobes is active at any time. The active row advances every 32 clocks, from row 0 through row 6 and back to row 0.
- R3: All column outputs are 0 during the first clock (slot position 0) of every row slot.
- R4: With brightness code c in control bits [2:0], columns may be lit only at slot positions 1 to 2*N(c). N is 15, 12, 8, 6, 4, 3, 2 and 0 for codes 0 to 7, so code 7 keeps the display dark.
- R5: For a digit whose code has bit 7 clear, its row pattern is the font data for code bits [6:0]. With bit 7 set, the pattern is the user-glyph data for code bits [3:0]. Digit d drives columns [5d+4:5d], and bit 4 is the leftmost dot.
- R6: When control bit 3 is 1, a digit whose flash mask bit is 1 is dark during the hidden half of the phase period. When control bit 3 is 0, the flash mask has no effect.
- R7: When control bit 4 is 1, all digits are dark during the hidden half of the phase period, whatever control bit 3 and the flash mask hold.
- R8: A frame is 224 clocks (7 rows of 32). The phase period is 128 frames. Frames 0 to 63 are the visible half and frames 64 to 127 are the hidden half. The phase count restarts at frame 0 after every reset.
- R9: During slot positions 0 to 7, the lookup port presents the digit index equal to the slot position. The lookup row index is always the row that follows the active row, wrapping from 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Refresh oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 8 | Control: [2:0] brightness, [3] flash enable, [4] blink enable |
| flash_bits | input | 8 | Per-digit flash mask |
| fetch_digit | output | 3 | Digit index being looked up |
| fetch_row | output | 3 | Dot row being looked up (next row to display) |
| char_code | input | 8 | Stored code of digit fetch_digit |
| font_bits | input | 5 | Font row data for char_code[6:0] at fetch_row |
| udc_bits | input | 5 | User glyph row data for char_code[3:0] at fetch_row |
| col_out | output | 40 | Column drives, 5 per digit |
| row_strobe | output | 7 | One-hot row drives |

## Verification
The assertions check several properties on every cycle. They check that the strobes stay one-hot and rotate only at the slot end. They check that the columns are dark when the row changes, when the brightness code is 7, and while blink is active in the hidden half. They also check that the row and phase counters hold between their update points. Only the bench scenarios can show the rest. These are the exact lit window for each brightness code, the choice between font and user glyph with the correct column placement, the flash mask being ignored when disabled, and blink winning over flash. The bench also shows that the phase half flips exactly at frame 64 and restarts after a mid-run reset.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

    // Lit sub-steps out of a 15-step grid for each brightness code.
    function automatic logic [3:0] duty_steps(input logic [2:0] code);
        case (code)
            3'd0:    duty_steps = 4'd15;
            3'd1:    duty_steps = 4'd12;
            3'd2:    duty_steps = 4'd8;
            3'd3:    duty_steps = 4'd6;
            3'd4:    duty_steps = 4'd4;
            3'd5:    duty_steps = 4'd3;
            3'd6:    duty_steps = 4'd2;
            default: duty_steps = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/rowscan_timer.sv
module rowscan_timer #(
    parameter int SLOT_CLKS    = 32,
    parameter int ROWS         = 7,
    parameter int PHASE_FRAMES = 128,
    localparam int SLOT_W      = $clog2(SLOT_CLKS),
    localparam int ROW_W       = $clog2(ROWS),
    localparam int FRAME_W     = $clog2(PHASE_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [ROW_W-1:0]  next_row_o,
    output logic              slot_end_o,
    output logic              phase_next_o
);

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [ROW_W-1:0]   row;
        logic [FRAME_W-1:0] frame;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_slot, last_row;
    logic [ROW_W-1:0] row_inc;

    always_comb begin
        last_slot = (tmr_q.slot == SLOT_W'(SLOT_CLKS - 1));
        last_row  = (tmr_q.row == ROW_W'(ROWS - 1));
        row_inc   = last_row ? '0 : tmr_q.row + ROW_W'(1);
        tmr_d     = tmr_q;
        tmr_d.slot = last_slot ? '0 : tmr_q.slot + SLOT_W'(1);
        if (last_slot) begin
            tmr_d.row = row_inc;
            if (last_row) begin
                tmr_d.frame = (tmr_q.frame == FRAME_W'(PHASE_FRAMES - 1))
                            ? '0 : tmr_q.frame + FRAME_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot_o       = tmr_q.slot;
    assign row_o        = tmr_q.row;
    assign next_row_o   = row_inc;
    assign slot_end_o   = last_slot;
    assign phase_next_o = tmr_d.frame[FRAME_W-1];

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.slot != SLOT_W'(SLOT_CLKS - 1)) |=> $stable(tmr_q.row)); // R2
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tmr_q.row) < ROWS)); // R2
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_slot && last_row) |=> $stable(tmr_q.frame)); // R8

endmodule

// File: rtl/rowscan_fetch.sv
module rowscan_fetch #(
    parameter int DIGITS   = 8,
    parameter int COLS     = 5,
    parameter int SLOT_W   = 5,
    parameter int ROW_W    = 3,
    localparam int DIG_W   = $clog2(DIGITS),
    localparam int GLYPH_W = DIGITS * COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic [ROW_W-1:0]   next_row_i,
    output logic [DIG_W-1:0]   fetch_digit,
    output logic [ROW_W-1:0]   fetch_row,
    input  logic [7:0]         char_code,
    input  logic [COLS-1:0]    font_bits,
    input  logic [COLS-1:0]    udc_bits,
    output logic [GLYPH_W-1:0] shadow_o
);

    typedef struct packed {
        logic [GLYPH_W-1:0] shadow;
    } fet_t;

    fet_t fet_d, fet_q;
    logic [COLS-1:0] pick;

    always_comb begin
        pick  = char_code[7] ? udc_bits : font_bits;
        fet_d = fet_q;
        if (int'(slot_i) < DIGITS) begin
            fet_d.shadow[int'(slot_i[DIG_W-1:0]) * COLS +: COLS] = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fet_q <= '0;
        else        fet_q <= fet_d;
    end

    assign fetch_digit = slot_i[DIG_W-1:0];
    assign fetch_row   = next_row_i;
    assign shadow_o    = fet_q.shadow;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot_i) >= DIGITS) |=> $stable(fet_q.shadow)); // R9

endmodule

// File: rtl/rowscan_drive.sv
module rowscan_drive
    import rowscan_pkg::*;
#(
    parameter int DIGITS    = 8,
    parameter int COLS      = 5,
    parameter int ROWS      = 7,
    parameter int SLOT_CLKS = 32,
    parameter int ROW_W     = 3,
    localparam int SLOT_W   = $clog2(SLOT_CLKS),
    localparam int GLYPH_W  = DIGITS * COLS,
    localparam int STEP     = SLOT_CLKS / 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic [ROW_W-1:0]   row_i,
    input  logic               slot_end_i,
    input  logic               phase_next_i,
    input  logic [GLYPH_W-1:0] shadow_i,
    input  logic [7:0]         ctrl_word,
    input  logic [DIGITS-1:0]  flash_bits,
    output logic [GLYPH_W-1:0] col_out,
    output logic [ROWS-1:0]    row_strobe
);

    typedef struct packed {
        logic [GLYPH_W-1:0] glyph;
        logic [2:0]         bright;
        logic               flash_en;
        logic               blink;
        logic [DIGITS-1:0]  fmask;
        logic               phase;
    } drv_t;

    drv_t drv_d, drv_q;
    logic lit;
    int   on_clks;

    always_comb begin
        drv_d = drv_q;
        if (slot_end_i) begin
            drv_d.glyph    = shadow_i;
            drv_d.bright   = ctrl_word[2:0];
            drv_d.flash_en = ctrl_word[3];
            drv_d.blink    = ctrl_word[4];
            drv_d.fmask    = flash_bits;
            drv_d.phase    = phase_next_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    always_comb begin
        on_clks = int'(duty_steps(drv_q.bright)) * STEP;
        lit     = (slot_i != '0) && (int'(slot_i) <= on_clks);
        row_strobe = '0;
        row_strobe[row_i] = 1'b1;
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic hide;
        assign hide = drv_q.phase & (drv_q.blink | (drv_q.flash_en & drv_q.fmask[g]));
        assign col_out[g*COLS +: COLS] = (lit && !hide) ? drv_q.glyph[g*COLS +: COLS] : '0;
    end

    AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_q.bright == 3'b111) |-> (col_out == '0)); // R4
    AST_BLINK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_q.blink && drv_q.phase) |-> (col_out == '0)); // R7
    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end_i |=> $stable(drv_q)); // R6

endmodule

// File: rtl/rowscan_refresh.sv
module rowscan_refresh #(
    parameter int DIGITS       = 8,
    parameter int COLS         = 5,
    parameter int ROWS         = 7,
    parameter int SLOT_CLKS    = 32,
    parameter int PHASE_FRAMES = 128,
    localparam int DIG_W       = $clog2(DIGITS),
    localparam int ROW_W       = $clog2(ROWS),
    localparam int SLOT_W      = $clog2(SLOT_CLKS),
    localparam int GLYPH_W     = DIGITS * COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         ctrl_word,
    input  logic [DIGITS-1:0]  flash_bits,
    output logic [DIG_W-1:0]   fetch_digit,
    output logic [ROW_W-1:0]   fetch_row,
    input  logic [7:0]         char_code,
    input  logic [COLS-1:0]    font_bits,
    input  logic [COLS-1:0]    udc_bits,
    output logic [GLYPH_W-1:0] col_out,
    output logic [ROWS-1:0]    row_strobe
);

    logic [SLOT_W-1:0]  slot;
    logic [ROW_W-1:0]   row, next_row;
    logic               slot_end, phase_next;
    logic [GLYPH_W-1:0] shadow;

    rowscan_timer #(
        .SLOT_CLKS(SLOT_CLKS), .ROWS(ROWS), .PHASE_FRAMES(PHASE_FRAMES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .row_o(row),
        .next_row_o(next_row), .slot_end_o(slot_end), .phase_next_o(phase_next)
    );

    rowscan_fetch #(
        .DIGITS(DIGITS), .COLS(COLS), .SLOT_W(SLOT_W), .ROW_W(ROW_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .next_row_i(next_row),
        .fetch_digit(fetch_digit), .fetch_row(fetch_row), .char_code(char_code),
        .font_bits(font_bits), .udc_bits(udc_bits), .shadow_o(shadow)
    );

    rowscan_drive #(
        .DIGITS(DIGITS), .COLS(COLS), .ROWS(ROWS), .SLOT_CLKS(SLOT_CLKS), .ROW_W(ROW_W)
    ) u_drive (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .row_i(row), .slot_end_i(slot_end),
        .phase_next_i(phase_next), .shadow_i(shadow), .ctrl_word(ctrl_word),
        .flash_bits(flash_bits), .col_out(col_out), .row_strobe(row_strobe)
    );

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(row_strobe)); // R2
    AST_ROW_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (row_strobe == (($past(row_strobe) << 1) | ($past(row_strobe) >> (ROWS - 1))))); // R2
    AST_DARK_AT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_strobe) |-> (col_out == '0)); // R3

endmodule

// File: tb/rowscan_refresh_bench.sv
`timescale 1ns/1ps
module rowscan_refresh_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl_word = 8'h00;
    logic [7:0]  flash_bits = 8'h00;
    logic [2:0]  fetch_digit;
    logic [2:0]  fetch_row;
    logic [7:0]  char_code;
    logic [4:0]  font_bits;
    logic [4:0]  udc_bits;
    logic [39:0] col_out;
    logic [6:0]  row_strobe;
    logic [7:0]  codes [8];

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    rowscan_refresh u_rowscan_refresh (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .flash_bits(flash_bits),
        .fetch_digit(fetch_digit), .fetch_row(fetch_row), .char_code(char_code),
        .font_bits(font_bits), .udc_bits(udc_bits), .col_out(col_out),
        .row_strobe(row_strobe)
    );

    function automatic [4:0] font_fn(input [6:0] c, input [2:0] r);
        font_fn = 5'(c * 3 + r * 7) ^ {r, 2'b01};
    endfunction

    function automatic [4:0] udc_fn(input [3:0] i, input [2:0] r);
        udc_fn = {i, r[0]} ^ 5'({r, 2'b00});
    endfunction

    always_comb begin
        char_code = codes[fetch_digit];
        font_bits = font_fn(char_code[6:0], fetch_row);
        udc_bits  = udc_fn(char_code[3:0], fetch_row);
    end

    function automatic int steps(input [2:0] b);
        case (b)
            3'd0: steps = 15; 3'd1: steps = 12; 3'd2: steps = 8; 3'd3: steps = 6;
            3'd4: steps = 4;  3'd5: steps = 3;  3'd6: steps = 2; default: steps = 0;
        endcase
    endfunction

    function automatic [39:0] exp_cols(input int n);
        int rs, slot, row, frame;
        logic phase, hide;
        logic [4:0] g;
        exp_cols = '0;
        rs = n / 32; slot = n % 32; row = rs % 7; frame = (rs / 7) % 128;
        phase = (frame >= 64);
        if (rs == 0 || slot == 0 || slot > 2 * steps(ctrl_word[2:0])) return exp_cols;
        for (int d = 0; d < 8; d++) begin
            g = codes[d][7] ? udc_fn(codes[d][3:0], 3'(row)) : font_fn(codes[d][6:0], 3'(row));
            hide = phase && (ctrl_word[4] || (ctrl_word[3] && flash_bits[d]));
            if (!hide) exp_cols[d*5 +: 5] = g;
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic check_now(input string tag);
        int slot, row;
        slot = cyc % 32; row = (cyc / 32) % 7;
        check((slot == 0) ? "R3" : tag, 64'(col_out), 64'(exp_cols(cyc)));
        check("R2", 64'(row_strobe), 64'(7'(1) << row));
        if (slot < 8) check("R9 digit", 64'(fetch_digit), 64'(slot));
        check("R9 row", 64'(fetch_row), 64'((row + 1) % 7));
    endtask

    task automatic run_case(input string tag, input int n);
        int rs0;
        rs0 = cyc / 32;
        while (cyc / 32 < rs0 + 2) @(negedge clk);
        repeat (n) begin
            check_now(tag);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 strobe", 64'(row_strobe), 64'd1);
        check("R1 cols", 64'(col_out), 64'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int d = 0; d < 8; d++) codes[d] = 8'h20;
        do_reset();

        // R5: mixed font and user-glyph codes at full brightness
        codes[0] = 8'h41; codes[1] = 8'h85; codes[2] = 8'h7F; codes[3] = 8'h8F;
        codes[4] = 8'h00; codes[5] = 8'h80; codes[6] = 8'h5A; codes[7] = 8'hF3;
        ctrl_word = 8'h00;
        run_case("R5", 250);

        // R4: every brightness code, including the blank code 7
        for (int b = 0; b < 8; b++) begin
            ctrl_word = 8'(b);
            run_case("R4", 70);
        end

        // move into the hidden half of the phase period (frame 64)
        ctrl_word = 8'h00;
        while (cyc < 64 * 224 + 40) @(negedge clk);

        ctrl_word = 8'h08; flash_bits = 8'hA5;
        run_case("R6", 100);
        ctrl_word = 8'h00; flash_bits = 8'hFF;
        run_case("R6", 100);
        ctrl_word = 8'h12; flash_bits = 8'h00;
        run_case("R7", 100);
        ctrl_word = 8'h1B; flash_bits = 8'h3C;
        run_case("R7", 100);

        // random mix across the end of the hidden half and into the next period
        while (cyc < 34000) begin
            ctrl_word = 8'($urandom_range(0, 31));
            flash_bits = 8'($urandom);
            for (int d = 0; d < 8; d++) codes[d] = 8'($urandom);
            if (ctrl_word[4])      run_case("R7", 64);
            else if (ctrl_word[3]) run_case("R6", 64);
            else                   run_case("R5", 64);
        end

        // R8: reset while blinking restarts the phase in its visible half
        ctrl_word = 8'h10; flash_bits = 8'hFF;
        while (((cyc / 224) % 128) < 70) @(negedge clk);
        do_reset();
        run_case("R8", 200);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule